// File: doc/BRIEF.md
# Multichannel Routed Sample Delay

This block delays six 24-bit sample channels by a programmable number of whole samples each. All six delay lines share one sample memory. Each channel gets a region of that memory whose size equals its delay, and the regions are packed one after another. Every output channel also picks its source from any of the six inputs, so one input can feed several delayed copies.

Samples pass through untouched, bit for bit, so non-audio payloads survive. A delay of zero gives a straight passthrough. Longer delays can be built by chaining several instances in series.

The block does one step per sample strobe. After a strobe, it works through the six channels one per clock on a single memory port. It then updates all six outputs together and pulses a valid flag. A small write-only configuration port sets the delays and the routing. A flag reports when the programmed delays do not fit in the pool, or when one delay exceeds the per-channel limit. While that flag is set, all outputs are muted.

Top module: `mc_route_delay`

## Requirements
- R1: After reset, `dout` is all zero, `out_vld` and `pool_err` are low, every delay is zero and output k takes input k.
- R2: A strobe taken while idle makes `out_vld` high for exactly one cycle, CH+2 clock edges after the edge that sampled the strobe. `dout` changes only together with that pulse.
- R3: An output whose delay is zero carries its selected input from the same strobe, unchanged in every bit.
- R4: A delay of D (written at configuration address k, 0 to CH-1, low DLY_W data bits) makes output k carry its routed input from D strobes earlier, bit-exact.
- R5: Writing value s to configuration address CH_SLOTS+k (address MSB set, low bits k) makes output k take input s. The route takes effect from the next strobe, and the delay lines are not restarted. Values of s of CH or more are ignored.
- R6: Any delay write restarts every delay line. For the first D strobes after the write, a channel with delay D outputs zero. Stale memory contents never appear.
- R7: `pool_err` is high when the sum of all delays exceeds POOL_DEPTH. Two channels of POOL_DEPTH/2 each fit; one more sample on either sets the flag.
- R8: `pool_err` is high when any single delay exceeds MAX_DLY. A delay equal to MAX_DLY is accepted.
- R9: While `pool_err` is high, every output of each completed step is zero, including outputs with zero delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe; ignored while a step is in progress |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | SEL_W+1 | MSB 0: delay of channel; MSB 1: route of output; low bits: channel |
| cfg_wdata | input | DLY_W | Delay in samples, or source index in the low SEL_W bits |
| din | input | CH*DW | Input samples, channel k in bits k*DW upward |
| dout | output | CH*DW | Delayed, routed samples, same packing |
| out_vld | output | 1 | One-cycle pulse when `dout` holds a new step |
| pool_err | output | 1 | Delay configuration exceeds the pool or the per-channel limit |

## Verification
The bench builds the block with a 32-entry pool and a per-channel limit of 20 samples. This makes pool overflow, the two-channel half-pool boundary and the per-channel ceiling reachable within a few dozen strobes. Delays of up to 20 samples are then observed over their full fill period, with silence before data appears. The default 6-channel, 24-bit shape is kept, so the routing matrix, the slot timing and bit-exact passthrough are exercised at their production widths.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_RUN    = 2'd1,
      PH_COMMIT = 2'd2
   } mcd_phase_e;

   function automatic bit mcd_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/mcd_cfg_regs.sv
module mcd_cfg_regs #(
   parameter int CH         = 6,
   parameter int DLY_W      = 13,
   parameter int SEL_W      = 3,
   parameter int SUM_W      = 17,
   parameter int POOL_DEPTH = 2048,
   parameter int MAX_DLY    = 8121
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [SEL_W:0]        addr,
   input  logic [DLY_W-1:0]      wdata,
   output logic [CH*DLY_W-1:0]   dly_flat,
   output logic [CH*SEL_W-1:0]   sel_flat,
   output logic [CH*SUM_W-1:0]   base_flat,
   output logic                  restart,
   output logic                  err
);
   logic [DLY_W-1:0] dly_q [CH];
   logic [SEL_W-1:0] sel_q [CH];
   logic [SUM_W-1:0] base_a [CH];
   logic [SUM_W-1:0] total;
   logic [CH-1:0]    over_max;
   logic             is_route;
   logic             src_ok;

   assign is_route = addr[SEL_W];
   assign src_ok   = wdata < DLY_W'(CH);
   assign restart  = we && !is_route && (addr[SEL_W-1:0] < SEL_W'(CH));

   for (genvar i = 0; i < CH; i++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dly_q[i] <= '0;
            sel_q[i] <= SEL_W'(i);
         end else if (we && addr[SEL_W-1:0] == SEL_W'(i)) begin
            if (!is_route)
               dly_q[i] <= wdata;
            else if (src_ok)
               sel_q[i] <= wdata[SEL_W-1:0];
         end
      end

      always_comb begin
         base_a[i] = '0;
         for (int j = 0; j < i; j++)
            base_a[i] = base_a[i] + SUM_W'(dly_q[j]);
      end

      assign over_max[i]                 = dly_q[i] > DLY_W'(MAX_DLY);
      assign dly_flat[i*DLY_W +: DLY_W]  = dly_q[i];
      assign sel_flat[i*SEL_W +: SEL_W]  = sel_q[i];
      assign base_flat[i*SUM_W +: SUM_W] = base_a[i];
   end

   assign total = base_a[CH-1] + SUM_W'(dly_q[CH-1]);
   assign err   = (total > SUM_W'(POOL_DEPTH)) || (|over_max);
endmodule

// File: rtl/mcd_xbar.sv
module mcd_xbar #(
   parameter int CH    = 6,
   parameter int DW    = 24,
   parameter int SEL_W = 3
) (
   input  logic [CH*DW-1:0]    din,
   input  logic [CH*SEL_W-1:0] sel_flat,
   output logic [CH*DW-1:0]    routed
);
   for (genvar k = 0; k < CH; k++) begin : g_out
      logic [SEL_W-1:0] sel;
      assign sel = sel_flat[k*SEL_W +: SEL_W];
      assign routed[k*DW +: DW] = din[int'(sel)*DW +: DW];
   end
endmodule

// File: rtl/mcd_engine.sv
module mcd_engine
   import mcd_pkg::*;
#(
   parameter int CH         = 6,
   parameter int DW         = 24,
   parameter int DLY_W      = 13,
   parameter int SUM_W      = 17,
   parameter int POOL_DEPTH = 2048
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb,
   input  logic                restart,
   input  logic                err,
   input  logic [CH*DW-1:0]    routed,
   input  logic [CH*DLY_W-1:0] dly_flat,
   input  logic [CH*SUM_W-1:0] base_flat,
   output logic [CH*DW-1:0]    dout,
   output logic                out_vld
);
   localparam int AW     = $clog2(POOL_DEPTH);
   localparam int SLOT_W = $clog2(CH);

   logic [DW-1:0]    mem [POOL_DEPTH];
   logic [DW-1:0]    routed_a [CH];
   logic [DLY_W-1:0] dly_a [CH];
   logic [SUM_W-1:0] base_a [CH];
   logic [DW-1:0]    cap [CH];
   logic [DW-1:0]    stage [CH];
   logic [DW-1:0]    dout_q [CH];
   logic [DLY_W-1:0] ptr [CH];
   logic [CH-1:0]    fill;

   mcd_phase_e        phase;
   logic [SLOT_W-1:0] slot;
   logic [DLY_W-1:0]  d_cur;
   logic [SUM_W-1:0]  addr_wide;
   logic [AW-1:0]     addr;
   logic              in_pool;
   logic              do_wr;
   logic [DW-1:0]     rd;
   logic [DW-1:0]     val;

   for (genvar i = 0; i < CH; i++) begin : g_unpack
      assign routed_a[i]        = routed[i*DW +: DW];
      assign dly_a[i]           = dly_flat[i*DLY_W +: DLY_W];
      assign base_a[i]          = base_flat[i*SUM_W +: SUM_W];
      assign dout[i*DW +: DW]   = dout_q[i];
   end

   always_comb begin
      d_cur     = dly_a[slot];
      addr_wide = base_a[slot] + SUM_W'(ptr[slot]);
      in_pool   = addr_wide < SUM_W'(POOL_DEPTH);
      addr      = addr_wide[AW-1:0];
      rd        = mem[addr];
      do_wr     = (phase == PH_RUN) && (d_cur != '0) && !err && in_pool;
      if (d_cur == '0)
         val = cap[slot];
      else if (fill[slot] && in_pool)
         val = rd;
      else
         val = '0;
   end

   always_ff @(posedge clk) begin
      if (do_wr)
         mem[addr] <= cap[slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         slot    <= '0;
         out_vld <= 1'b0;
         fill    <= '0;
         for (int i = 0; i < CH; i++) begin
            cap[i]    <= '0;
            stage[i]  <= '0;
            dout_q[i] <= '0;
            ptr[i]    <= '0;
         end
      end else begin
         out_vld <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (stb) begin
                  for (int i = 0; i < CH; i++)
                     cap[i] <= routed_a[i];
                  slot  <= '0;
                  phase <= PH_RUN;
               end
            end
            PH_RUN: begin
               stage[slot] <= val;
               if (slot == SLOT_W'(CH - 1))
                  phase <= PH_COMMIT;
               else
                  slot <= slot + 1'b1;
            end
            default: begin
               for (int i = 0; i < CH; i++)
                  dout_q[i] <= err ? '0 : stage[i];
               out_vld <= 1'b1;
               phase   <= PH_IDLE;
            end
         endcase

         if (restart) begin
            fill <= '0;
            for (int i = 0; i < CH; i++)
               ptr[i] <= '0;
         end else if (do_wr) begin
            if (ptr[slot] == d_cur - 1'b1) begin
               ptr[slot]  <= '0;
               fill[slot] <= 1'b1;
            end else begin
               ptr[slot] <= ptr[slot] + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mc_route_delay.sv
module mc_route_delay
   import mcd_pkg::*;
#(
   parameter int CH         = 6,
   parameter int DW         = 24,
   parameter int DLY_W      = 13,
   parameter int POOL_DEPTH = 2048,
   parameter int MAX_DLY    = 8121,
   parameter int SEL_W      = $clog2(CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_stb,
   input  logic                cfg_we,
   input  logic [SEL_W:0]      cfg_addr,
   input  logic [DLY_W-1:0]    cfg_wdata,
   input  logic [CH*DW-1:0]    din,
   output logic [CH*DW-1:0]    dout,
   output logic                out_vld,
   output logic                pool_err
);
   localparam int SUM_W = DLY_W + SEL_W + 1;

   if (CH < 2 || DW < 1) begin : g_bad_shape
      $error("mc_route_delay: CH must be at least 2 and DW positive");
   end
   if (!mcd_is_pow2(POOL_DEPTH)) begin : g_bad_pool
      $error("mc_route_delay: POOL_DEPTH must be a power of two");
   end
   if (MAX_DLY >= (1 << DLY_W)) begin : g_bad_max
      $error("mc_route_delay: MAX_DLY must fit in DLY_W bits");
   end
   if (SUM_W <= $clog2(POOL_DEPTH)) begin : g_bad_sum
      $error("mc_route_delay: DLY_W too narrow for POOL_DEPTH");
   end

   logic [CH*DLY_W-1:0] dly_flat;
   logic [CH*SEL_W-1:0] sel_flat;
   logic [CH*SUM_W-1:0] base_flat;
   logic [CH*DW-1:0]    routed;
   logic                restart;

   mcd_cfg_regs #(
      .CH(CH), .DLY_W(DLY_W), .SEL_W(SEL_W), .SUM_W(SUM_W),
      .POOL_DEPTH(POOL_DEPTH), .MAX_DLY(MAX_DLY)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .dly_flat(dly_flat), .sel_flat(sel_flat),
      .base_flat(base_flat), .restart(restart), .err(pool_err)
   );

   mcd_xbar #(.CH(CH), .DW(DW), .SEL_W(SEL_W)) u_xbar (
      .din(din), .sel_flat(sel_flat), .routed(routed)
   );

   mcd_engine #(
      .CH(CH), .DW(DW), .DLY_W(DLY_W), .SUM_W(SUM_W), .POOL_DEPTH(POOL_DEPTH)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .restart(restart),
      .err(pool_err), .routed(routed), .dly_flat(dly_flat),
      .base_flat(base_flat), .dout(dout), .out_vld(out_vld)
   );
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
   parameter int CH = 6,
   parameter int DW = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_stb,
   input logic [CH*DW-1:0] dout,
   input logic             out_vld,
   input logic             pool_err
);
   // R2: the valid flag is a single-cycle pulse
   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);

   // R2: every valid pulse traces back to a strobe CH+2 edges earlier
   p_vld_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(smp_stb, CH + 2));

   // R2: outputs move only together with the valid pulse
   p_dout_on_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> out_vld);

   // R9: a step completed under the error flag is silent
   p_mute_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && $past(pool_err)) |-> (dout == '0));
endmodule

bind mc_route_delay mcd_checker #(.CH(CH), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .dout(dout),
   .out_vld(out_vld), .pool_err(pool_err)
);

// File: tb/tb_mc_route_delay.sv
`timescale 1ns/1ps
module tb_mc_route_delay;
   localparam int CH    = 6;
   localparam int DW    = 24;
   localparam int DLY_W = 13;
   localparam int POOL  = 32;
   localparam int MAXD  = 20;
   localparam int SEL_W = 3;
   localparam int HN    = 64;
   localparam int NROW  = 5;

   // table: write-delays flag, delays, routes, number of strobes
   localparam int T_WD [NROW]     = '{1, 1, 0, 1, 1};
   localparam int T_DLY [NROW][CH] = '{'{0,0,0,0,0,0}, '{1,2,3,5,8,0},
                                      '{1,2,3,5,8,0}, '{16,16,0,0,0,0},
                                      '{0,0,0,0,0,20}};
   localparam int T_RT [NROW][CH]  = '{'{0,1,2,3,4,5}, '{0,1,2,3,4,5},
                                      '{5,4,3,2,1,0}, '{0,1,2,3,4,5},
                                      '{2,2,2,2,2,2}};
   localparam int T_N [NROW]      = '{3, 12, 10, 20, 24};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic cfg_we = 1'b0;
   logic [SEL_W:0] cfg_addr = '0;
   logic [DLY_W-1:0] cfg_wdata = '0;
   logic [CH*DW-1:0] din = '0;
   logic [CH*DW-1:0] dout;
   logic out_vld, pool_err;

   int errors = 0;
   int checks = 0;
   int m_dly [CH];
   int m_rt [CH];
   int n_frm = 0;
   int fr = 0;
   logic [DW-1:0] rh [HN][CH];

   always #2.5 clk = ~clk;

   mc_route_delay #(.CH(CH), .DW(DW), .DLY_W(DLY_W), .POOL_DEPTH(POOL),
                    .MAX_DLY(MAXD)) dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din), .dout(dout),
      .out_vld(out_vld), .pool_err(pool_err));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit model_err();
      int s = 0;
      bit e = 0;
      for (int c = 0; c < CH; c++) begin
         s += m_dly[c];
         if (m_dly[c] > MAXD) e = 1;
      end
      return e || (s > POOL);
   endfunction

   function automatic logic [DW-1:0] gen(input int f, input int c);
      logic [31:0] x;
      if ((f + c) % 5 == 0) return '1;
      if ((f + c) % 7 == 0) return 24'hA5A5A5;
      x = (f + 1) * 32'h9E3779B1 ^ (c + 3) * 32'h85EBCA77;
      return x[31:8] ^ x[23:0];
   endfunction

   task automatic cfg_write(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = (SEL_W+1)'(a); cfg_wdata = DLY_W'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < CH) begin
         m_dly[a] = d; n_frm = 0;
      end else if (a >= 8 && a < 8 + CH && d < CH) begin
         m_rt[a-8] = d;
      end
   endtask

   task automatic do_frame(input string tag);
      logic [CH*DW-1:0] v;
      logic [DW-1:0] exp;
      int k;
      for (int c = 0; c < CH; c++) v[c*DW +: DW] = gen(fr, c);
      fr++;
      din = v;
      for (int c = 0; c < CH; c++) rh[n_frm % HN][c] = v[m_rt[c]*DW +: DW];
      @(negedge clk) smp_stb = 1'b1;
      @(negedge clk) smp_stb = 1'b0;
      k = 1;
      while (!out_vld && k < 40) begin
         @(negedge clk);
         k++;
      end
      chk(k == CH + 2, "R2 strobe-to-valid latency", 64'(k), 64'(CH + 2));
      for (int c = 0; c < CH; c++) begin
         if (model_err() || m_dly[c] > n_frm) exp = '0;
         else exp = rh[(n_frm - m_dly[c]) % HN][c];
         chk(dout[c*DW +: DW] == exp, tag, 64'(dout[c*DW +: DW]), 64'(exp));
      end
      n_frm++;
      @(negedge clk);
      chk(!out_vld, "R2 valid lasts one cycle", 64'(out_vld), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < CH; c++) begin
         m_dly[c] = 0; m_rt[c] = c;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(dout == '0, "R1 dout zero after reset", 64'(dout[63:0]), 64'd0);
      chk(!out_vld, "R1 no valid after reset", 64'(out_vld), 64'd0);
      chk(!pool_err, "R1 no error after reset", 64'(pool_err), 64'd0);
      do_frame("R1 default identity passthrough");

      // table walk: R3 R4 R5 R6 R7 R8
      for (int r = 0; r < NROW; r++) begin
         if (T_WD[r] != 0)
            for (int c = 0; c < CH; c++) cfg_write(c, T_DLY[r][c]);
         for (int c = 0; c < CH; c++) cfg_write(8 + c, T_RT[r][c]);
         chk(pool_err == model_err(), "R7 R8 error flag for table row",
             64'(pool_err), 64'(model_err()));
         for (int f = 0; f < T_N[r]; f++)
            do_frame($sformatf("R3 R4 R5 R6 table row %0d", r));
      end

      // R5: out-of-range source ignored
      cfg_write(8, 7);
      do_frame("R5 route value 7 ignored");

      // R7: pool overflow by one sample across a stereo pair
      for (int c = 0; c < CH; c++) cfg_write(c, 0);
      cfg_write(0, 16);
      cfg_write(1, 17);
      chk(pool_err, "R7 pool overflow 16+17", 64'(pool_err), 64'd1);
      do_frame("R9 muted while overflowed");
      cfg_write(1, 16);
      chk(!pool_err, "R7 half pool each fits", 64'(pool_err), 64'd0);

      // R8: per-channel ceiling
      cfg_write(1, 0);
      cfg_write(0, MAXD + 1);
      chk(pool_err, "R8 delay above limit", 64'(pool_err), 64'd1);
      do_frame("R9 muted above limit");
      cfg_write(0, MAXD);
      chk(!pool_err, "R8 delay at limit", 64'(pool_err), 64'd0);
      for (int f = 0; f < MAXD + 2; f++) do_frame("R4 R6 delay at limit");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule